// File: doc/BRIEF.md
# SD Card Clock Generator

This block derives the card clock from the fast host clock. Software writes a 32-bit control word through a plain write port and can read it back. The word holds a one-hot divisor field, a clock-enable bit, an automatic-stop bit and a pass-through bit. The divided clock is a registered square wave. In pass-through mode the host clock is gated by an enable flop that changes only while the host clock is low. The output never shows a shortened high or low phase.

A five-state machine runs the output. The states are IDLE_OFF (gated off), PH_LOW (low half-period), PH_HIGH (high half-period), PARKED (held low by automatic stop) and PASS (host clock passed through).

The transitions are:
- IDLE_OFF→PH_LOW, IDLE_OFF→PASS or IDLE_OFF→PARKED when the enable is seen. This is the only point where the divisor is latched.
- PH_LOW→PH_HIGH when the low count expires. From the end of PH_LOW the machine goes instead to IDLE_OFF if disabled, or to PARKED on an automatic stop.
- PH_HIGH→PH_LOW or PH_HIGH→IDLE_OFF when the high count expires.
- PARKED→PH_LOW or PARKED→PASS when busy returns, and PARKED→IDLE_OFF when disabled.
- PASS→PARKED on an automatic stop, and PASS→IDLE_OFF when disabled.

The `busy` input reports that a command or data transfer is under way. With automatic stop on, the clock is held low while `busy` is low.

Top module: `sdclk_gen`

## Requirements
- R1: After reset the control word reads 0 and `card_clk` is low.
- R2: Only these bits are stored and read back: [7:0] divisor, 8 enable, 9 automatic stop, 10 pass-through, and 16 (only when EXTENDED=1). All other bits read 0. When `wr_en` is low the stored word does not change.
- R3: With exactly bit n of [7:0] set (n=0..7), the period is 2^(n+2) host cycles and the clock is high for exactly half of it.
- R4: With bits [7:0], 10 and 16 all clear, the period is 2 host cycles (1 high, 1 low).
- R5: With bit 10 set and no other divisor bit, `card_clk` follows the host clock: high while the host clock is high, low while it is low.
- R6: With EXTENDED=1, bit 16 gives a period of 1024 host cycles. With EXTENDED=0, bit 16 is not stored and has no effect on the ratio.
- R7: When several divisor bits are set, bit 16 (if extended) wins. Next comes the highest set bit of [7:0], then bit 10.
- R8: With the enable bit (8) clear, `card_clk` stays low. Clearing the enable lets the current high phase finish at full length before the output stops low.
- R9: After an enabling write is accepted at edge e0, the output is low until its first rise, which comes at edge e0+R/2+1 for a ratio R ≥ 2.
- R10: A divisor written while the clock is enabled has no effect on the running ratio. It takes effect after the enable has been cleared and set again.
- R11: With bit 9 set and `busy` low, the clock parks low at the end of a low phase, and in PASS it parks at once. A rise of `busy` at edge e0 resumes it with a full low phase, and the first rise comes at e0+R/2+1. With bit 9 clear, `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Stored control word |
| busy | input | 1 | High while a command or data transfer is active |
| card_clk | output | 1 | Card clock |

## Verification
A bad divisor latch or decode shows up at once as a wrong period or a wrong high time, within one card-clock period of the first rise. A corrupt phase counter appears as an uneven duty cycle or a wrong first-rise latency. A wrong stop path shows up as a pulse that is too short, or as a clock that keeps running while disabled or parked, within two card periods of the triggering write or `busy` edge. A pass-through gate fault appears as a high level during the host-low half, checked on both host edges.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
    localparam int CTRL_W      = 32;
    localparam int FIELD_W     = 8;
    localparam int SHIFT_W     = 4;
    localparam int BIT_EN      = 8;
    localparam int BIT_AUTO    = 9;
    localparam int BIT_PASS    = 10;
    localparam int BIT_X1024   = 16;

    typedef enum logic [2:0] {
        IDLE_OFF = 3'd0,
        PH_LOW   = 3'd1,
        PH_HIGH  = 3'd2,
        PARKED   = 3'd3,
        PASS     = 3'd4
    } clk_state_t;
endpackage

// File: rtl/sdclk_ctrl_reg.sv
module sdclk_ctrl_reg
    import sdclk_pkg::*;
#(
    parameter bit EXTENDED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl_q
);
    localparam logic [CTRL_W-1:0] BASE_MASK =
        (CTRL_W'(1) << BIT_EN) | (CTRL_W'(1) << BIT_AUTO) |
        (CTRL_W'(1) << BIT_PASS) | CTRL_W'((1 << FIELD_W) - 1);
    localparam logic [CTRL_W-1:0] KEEP_MASK =
        EXTENDED ? (BASE_MASK | (CTRL_W'(1) << BIT_X1024)) : BASE_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_data & KEEP_MASK;
        end
    end

    // R2: no write, no change
    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/sdclk_ratio_dec.sv
module sdclk_ratio_dec
    import sdclk_pkg::*;
#(
    parameter bit EXTENDED = 1'b1
) (
    input  logic [CTRL_W-1:0]  ctrl,
    output logic [SHIFT_W-1:0] shift,
    output logic               pass_sel
);
    logic [SHIFT_W-1:0] field_shift;
    logic               field_any;

    always_comb begin
        field_shift = '0;
        field_any   = 1'b0;
        for (int i = 0; i < FIELD_W; i++) begin
            if (ctrl[i]) begin
                field_shift = SHIFT_W'(i + 2);
                field_any   = 1'b1;
            end
        end
    end

    always_comb begin
        pass_sel = 1'b0;
        if (EXTENDED && ctrl[BIT_X1024]) begin
            shift = SHIFT_W'(FIELD_W + 2);
        end else if (field_any) begin
            shift = field_shift;
        end else if (ctrl[BIT_PASS]) begin
            shift    = '0;
            pass_sel = 1'b1;
        end else begin
            shift = SHIFT_W'(1);
        end
    end
endmodule

// File: rtl/sdclk_fsm.sv
module sdclk_fsm
    import sdclk_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               auto_stop,
    input  logic               busy,
    input  logic [SHIFT_W-1:0] shift_in,
    input  logic               pass_in,
    output logic               card_clk
);
    clk_state_t          st_q, st_d;
    logic [CNT_W-1:0]    cnt_q;
    logic [SHIFT_W-1:0]  act_shift_q;
    logic                act_pass_q;
    logic                clk_q;
    logic                gate_q;
    logic                park_req;
    logic [CNT_W:0]      load_half;
    logic [CNT_W:0]      act_half;
    logic                load_phase;

    function automatic logic [CNT_W:0] half_of(input logic [SHIFT_W-1:0] s);
        if (s == '0) return (CNT_W+1)'(1);
        return (CNT_W+1)'(1) << (s - SHIFT_W'(1));
    endfunction

    assign park_req   = auto_stop && !busy;
    assign act_half   = half_of(act_shift_q);
    assign load_half  = (st_q == IDLE_OFF) ? half_of(shift_in) : act_half;
    assign load_phase = ((st_d == PH_LOW) || (st_d == PH_HIGH)) && (st_d != st_q);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IDLE_OFF: if (en) st_d = park_req ? PARKED : (pass_in ? PASS : PH_LOW);
            PH_LOW: begin
                if (cnt_q == '0) begin
                    if (!en)           st_d = IDLE_OFF;
                    else if (park_req) st_d = PARKED;
                    else               st_d = PH_HIGH;
                end
            end
            PH_HIGH:  if (cnt_q == '0) st_d = en ? PH_LOW : IDLE_OFF;
            PARKED: begin
                if (!en)            st_d = IDLE_OFF;
                else if (!park_req) st_d = act_pass_q ? PASS : PH_LOW;
            end
            PASS: begin
                if (!en)           st_d = IDLE_OFF;
                else if (park_req) st_d = PARKED;
            end
            default: st_d = IDLE_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= IDLE_OFF;
        else        st_q <= st_d;
    end

    // outputs, counter and latched ratio
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            clk_q       <= 1'b0;
            act_shift_q <= SHIFT_W'(1);
            act_pass_q  <= 1'b0;
        end else begin
            if (st_q == IDLE_OFF) begin
                act_shift_q <= shift_in;
                act_pass_q  <= pass_in;
            end
            if (load_phase)          cnt_q <= CNT_W'(load_half - (CNT_W+1)'(1));
            else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
            clk_q <= (st_d == PH_HIGH);
        end
    end

    // pass-through gate changes only while the host clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= (st_q == PASS);
    end

    assign card_clk = clk_q | (clk & gate_q);

    // checker state: length of the current high run of the divided output
    logic [CNT_W+1:0] hi_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_run <= '0;
        else if (clk_q) hi_run <= hi_run + 1'b1;
        else            hi_run <= '0;
    end

    // R3/R8: every high phase is full length, including the last one
    a_r3_full_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_q) |-> (hi_run == (CNT_W+2)'(act_half)));
    // R8: a rise needs the enable
    a_r8_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_q) |-> $past(en));
    // R11: no rise while an automatic stop is requested
    a_r11_no_rise_when_parked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_q) |-> ($past(busy) || !$past(auto_stop)));
    // R10: the running ratio only changes while gated off
    a_r10_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != IDLE_OFF) |=> $stable(act_shift_q));
    // R5: divided path is silent while the host clock is passed through
    a_r5_pass_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q |-> !clk_q);
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter bit EXTENDED = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        busy,
    output logic        card_clk
);
    localparam int MAX_SHIFT = EXTENDED ? FIELD_W + 2 : FIELD_W + 1;
    localparam int CNT_W     = MAX_SHIFT - 1;

    logic [CTRL_W-1:0]  ctrl_q;
    logic [SHIFT_W-1:0] shift;
    logic               pass_sel;

    sdclk_ctrl_reg #(.EXTENDED(EXTENDED)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q)
    );

    sdclk_ratio_dec #(.EXTENDED(EXTENDED)) u_dec (
        .ctrl     (ctrl_q),
        .shift    (shift),
        .pass_sel (pass_sel)
    );

    sdclk_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctrl_q[BIT_EN]),
        .auto_stop (ctrl_q[BIT_AUTO]),
        .busy      (busy),
        .shift_in  (shift),
        .pass_in   (pass_sel),
        .card_clk  (card_clk)
    );

    assign rd_data = ctrl_q;

    // R7: the decoded ratio never exceeds the variant's largest ratio
    a_r7_ratio_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        int'(shift) <= MAX_SHIFT);
endmodule

// File: tb/sdclk_gen_tb.sv
module sdclk_gen_tb_top;
    localparam int PERIOD = 10;
    localparam logic [31:0] EN   = 32'h1 << 8;
    localparam logic [31:0] AUTO = 32'h1 << 9;
    localparam logic [31:0] DIV1 = 32'h1 << 10;
    localparam logic [31:0] X1K  = 32'h1 << 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        busy = 1'b1;
    logic [31:0] rd_m, rd_b;
    logic        card_clk_m, card_clk_b;

    int n_run = 0;
    int n_fail = 0;
    int prev_ratio = 2;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    sdclk_gen #(.EXTENDED(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_m), .busy(busy), .card_clk(card_clk_m));

    sdclk_gen #(.EXTENDED(1'b0)) dut_b (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_b), .busy(busy), .card_clk(card_clk_b));

    function automatic bit smp(input bit sel);
        return sel ? card_clk_b : card_clk_m;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1;
        wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic drain(input int cycles, input int half, input bit sel, input string req);
        int run = 0;
        bit seen_low = 1'b0;
        for (int k = 0; k < cycles; k++) begin
            tick();
            if (smp(sel)) begin
                if (seen_low) run++;
            end else begin
                if (run != 0) chk(run == half, req, run, half);
                run = 0;
                seen_low = 1'b1;
            end
        end
        chk(smp(sel) == 1'b0, req, smp(sel), 0);
    endtask

    task automatic wait_rise(input bit sel, input int limit, output int lat);
        bit pv = smp(sel);
        lat = 0;
        for (int k = 0; k < limit; k++) begin
            tick();
            lat++;
            if (!pv && smp(sel)) return;
            pv = smp(sel);
        end
        lat = -1;
    endtask

    task automatic measure(input bit sel, input int limit, output int per, output int hi);
        bit pv = 1'b1;
        per = 1;
        hi = 1;
        for (int k = 0; k < limit; k++) begin
            tick();
            if (!pv && smp(sel)) return;
            per++;
            if (smp(sel)) hi++;
            pv = smp(sel);
        end
        per = -1;
    endtask

    task automatic run_case(input logic [31:0] field, input int ratio, input bit sel, input string req);
        int lat, per, hi;
        wr(field);
        drain(2 * prev_ratio + 4, prev_ratio / 2, sel, "R8");
        wr(field | EN);
        wait_rise(sel, ratio + 8, lat);
        chk(lat == ratio / 2 + 1, "R9", lat, ratio / 2 + 1);
        measure(sel, ratio + 8, per, hi);
        chk(per == ratio, req, per, ratio);
        chk(hi == ratio / 2, req, hi, ratio / 2);
        prev_ratio = ratio;
    endtask

    task automatic pass_check(input bit exp_run, input string req);
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #2;
            chk(card_clk_m == exp_run, req, card_clk_m, exp_run);
            @(negedge clk); #2;
            chk(card_clk_m == 1'b0, req, card_clk_m, 0);
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int lat, per, hi, highs;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(rd_m == 32'h0, "R1", rd_m, 0);
        chk(card_clk_m == 1'b0, "R1", card_clk_m, 0);
        chk(card_clk_b == 1'b0, "R1", card_clk_b, 0);

        // R4 all clear gives /2; R3 sweep of one-hot bits; R6 /1024
        run_case(32'h0, 2, 1'b0, "R4");
        for (int n = 0; n < 8; n++) begin
            run_case(32'h1 << n, 1 << (n + 2), 1'b0, "R3");
        end
        run_case(X1K, 1024, 1'b0, "R6");

        // R7 priority
        run_case(32'h83, 512, 1'b0, "R7");
        run_case(X1K | 32'h1, 1024, 1'b0, "R7");
        run_case(DIV1 | 32'h4, 16, 1'b0, "R7");

        // R5 pass-through, also R7 lowest priority
        wr(DIV1);
        drain(2 * prev_ratio + 4, prev_ratio / 2, 1'b0, "R8");
        wr(DIV1 | EN);
        repeat (3) tick();
        pass_check(1'b1, "R5");
        wr(DIV1);
        repeat (3) tick();
        pass_check(1'b0, "R8");
        prev_ratio = 2;

        // R10 divisor change while enabled is ignored
        run_case(32'h1, 4, 1'b0, "R3");
        wr(EN | 32'h4);
        chk(rd_m == (EN | 32'h4), "R2", rd_m, EN | 32'h4);
        wait_rise(1'b0, 20, lat);
        measure(1'b0, 40, per, hi);
        chk(per == 4, "R10", per, 4);
        run_case(32'h4, 16, 1'b0, "R10");

        // R11 automatic stop
        wr(32'h1);
        drain(2 * prev_ratio + 4, prev_ratio / 2, 1'b0, "R8");
        busy = 1'b0;
        wr(EN | AUTO | 32'h1);
        highs = 0;
        for (int k = 0; k < 40; k++) begin tick(); highs += int'(card_clk_m); end
        chk(highs == 0, "R11", highs, 0);
        busy = 1'b1;
        wait_rise(1'b0, 20, lat);
        chk(lat == 3, "R11", lat, 3);
        measure(1'b0, 20, per, hi);
        chk(per == 4 && hi == 2, "R11", per, 4);
        busy = 1'b0;
        drain(12, 2, 1'b0, "R11");
        highs = 0;
        for (int k = 0; k < 20; k++) begin tick(); highs += int'(card_clk_m); end
        chk(highs == 0, "R11", highs, 0);
        wr(EN | 32'h1);
        wait_rise(1'b0, 20, lat);
        measure(1'b0, 20, per, hi);
        chk(per == 4, "R11", per, 4);
        wr(32'h1);
        drain(12, 2, 1'b0, "R8");
        wr(EN | AUTO | DIV1);
        repeat (3) tick();
        pass_check(1'b0, "R11");
        busy = 1'b1;
        repeat (3) tick();
        pass_check(1'b1, "R11");
        wr(DIV1);
        repeat (3) tick();
        prev_ratio = 2;

        // R6 base variant ignores bit 16
        run_case(X1K, 2, 1'b1, "R6");
        chk(rd_b == EN, "R6", rd_b, EN);
        chk(rd_m == (X1K | EN), "R2", rd_m, X1K | EN);

        // R2 readback masking, R8 disabled output
        wr(32'hFFFF_FEFF);
        chk(rd_m == 32'h0001_06FF, "R2", rd_m, 32'h0001_06FF);
        chk(rd_b == 32'h0000_06FF, "R2", rd_b, 32'h0000_06FF);
        drain(2100, 512, 1'b0, "R8");
        chk(card_clk_b == 1'b0, "R8", card_clk_b, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule